// File: doc/BRIEF.md
# SPI Slave Command Decoder

This block is the front end of an SPI slave (clock idle low, data sampled on the rising serial clock edge, most significant bit first). The serial clock, chip select and MOSI pins are brought into the system clock domain through two-flop synchronisers and oversampled there. After chip select goes low, the first eight bits from the master form a command byte. The byte selects one of four operations: write status, write buffer, read buffer or read status. The codes are either a fixed set or four programmable bytes. Each operation can have a dummy phase of its own, and the two buffer operations also have an address phase.

Writes to status land in a status register that the master owns. Buffer writes and reads move one 32-bit word through an external 16-word buffer port. Status reads return either the status the master last wrote or a status word supplied by the host. The block exposes the most recently decoded operation and a wrapping count of the operations that ran to completion. The serial clock half period must be at least four system clock cycles.

Top module: `spi_cmd_slave`

## Requirements
- R1: With `cmd_prog_en` low, the command byte values 1, 2, 3 and 4 select write status, write buffer, read buffer and read status. `last_cmd` then shows 1, 2, 3 or 4 for that operation, and it is 0 after reset.
- R2: With `cmd_prog_en` high, the codes come from `cmd_codes` instead: byte 0 (bits 7:0) is write status, byte 1 is write buffer, byte 2 is read buffer and byte 3 is read status. The fixed codes are then no longer recognised, unless they also equal a programmed code.
- R3: Write status takes in `stat_len`+1 bits after the command and any dummy phase. When the last bit arrives, `master_status` takes that value right-aligned and zero-extended.
- R4: Read status sends the low `stat_len`+1 bits of its source, most significant first. The source is `master_status` when `stat_rb_sel` is 1 and `host_status` when it is 0. MISO is 0 during the dummy phase. Each bit is valid before the serial clock edge that samples it.
- R5: Write buffer takes in `wbuf_alen`+1 address bits, whose low 4 bits name the word. It then runs its dummy phase if enabled, and takes in 32 data bits. It issues exactly one `buf_we` pulse, carrying that word and address.
- R6: Read buffer takes in `rbuf_alen`+1 address bits, runs its dummy phase if enabled, then shifts out the 32-bit word at that address, most significant first.
- R7: The dummy phase of each operation is turned on by its bit of `dummy_en` and lasts `dummy_len` field + 1 serial clock cycles. Bit and field index 0 is write status, 1 is write buffer, 2 is read buffer and 3 is read status, with 8-bit fields.
- R8: Chip select rising before an operation completes aborts it. Nothing is written and the operation is not counted. The next frame is decoded normally.
- R9: An unrecognised command byte is ignored until chip select rises. MISO stays 0, and `last_cmd`, `op_count` and `master_status` are unchanged.
- R10: A clear `sta_en` disables both status commands, and a clear `wbuf_en` or `rbuf_en` disables its buffer command. A disabled command is treated as unrecognised.
- R11: `op_count` increments by one for each completed operation and wraps from 15 to 0.
- R12: Asserting `rst_n` low, or holding `soft_clr` high for one cycle, returns `last_cmd`, `op_count`, `master_status`, `miso` and `buf_we` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of all slave state |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| cmd_prog_en | input | 1 | Use programmable command codes |
| cmd_codes | input | 32 | Four programmable command bytes |
| sta_en | input | 1 | Enable both status commands |
| wbuf_en | input | 1 | Enable the write buffer command |
| rbuf_en | input | 1 | Enable the read buffer command |
| dummy_en | input | 4 | Dummy phase enable per operation |
| dummy_len | input | 32 | Dummy length per operation, cycles minus one |
| wbuf_alen | input | 6 | Write buffer address length, bits minus one |
| rbuf_alen | input | 6 | Read buffer address length, bits minus one |
| stat_rb_sel | input | 1 | Read status source: 1 master status, 0 host status |
| stat_len | input | 5 | Status length, bits minus one |
| host_status | input | 32 | Status word supplied by the host |
| master_status | output | 32 | Status last written by the master |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | 4 | Buffer write word address |
| buf_wdata | output | 32 | Buffer write data |
| buf_raddr | output | 4 | Buffer read word address |
| buf_rdata | input | 32 | Buffer read data, combinational from buf_raddr |
| last_cmd | output | 3 | Last decoded operation |
| op_count | output | 4 | Completed operation counter |

## Verification
A pin change reaches the state machine through two synchroniser flops and one edge flop. Every register result therefore appears at the third system clock edge after the serial clock or chip select edge that causes it. MISO for the next bit follows two cycles later in the case of a read load. The bench runs the serial clock with a half period of eight system cycles. It changes MOSI half a serial period before each rising edge, and it samples MISO when it raises the clock, before the design can react to that edge. Status, counter and buffer results are sampled only after chip select has been high for six cycles, so every result is settled before it is compared.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  localparam int unsigned NUM_OPS = 4;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WSTA = 3'd1,
    OP_WBUF = 3'd2,
    OP_RBUF = 3'd3,
    OP_RSTA = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_LOAD,
    ST_DATA,
    ST_HALT
  } st_e;

  function automatic logic op_is_read(op_e op);
    return (op == OP_RBUF) || (op == OP_RSTA);
  endfunction

  // Reads need one system cycle to fetch their word before data starts.
  function automatic st_e data_entry(op_e op);
    return op_is_read(op) ? ST_LOAD : ST_DATA;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int unsigned WIDTH    = 3,
  parameter int unsigned STAGES   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0,
  parameter int unsigned EDGE_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             rise_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic             edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
      edge_q <= RST_VAL[EDGE_BIT];
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      edge_q <= stage_q[STAGES-1][EDGE_BIT];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1][EDGE_BIT] & ~edge_q;

endmodule

// File: rtl/spi_cmd_match.sv
`timescale 1ns/1ps
module spi_cmd_match
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned N_OPS  = NUM_OPS
) (
  input  logic [CODE_W-1:0]       code_i,
  input  logic                    prog_en_i,
  input  logic [N_OPS*CODE_W-1:0] prog_codes_i,
  input  logic [N_OPS-1:0]        op_en_i,
  output op_e                     op_o,
  output logic                    hit_o
);

  logic [N_OPS-1:0] hit;

  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    logic [CODE_W-1:0] ref_code;
    assign ref_code = prog_en_i ? prog_codes_i[i*CODE_W +: CODE_W]
                                : CODE_W'(i + 1);
    assign hit[i]   = op_en_i[i] && (code_i == ref_code);
  end

  // Lowest operation index wins when programmed codes collide.
  always_comb begin
    op_o  = OP_NONE;
    hit_o = |hit;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (hit[i]) op_o = op_e'(3'(i + 1));
    end
  end

  // R1
  always_comb begin
    if (!prog_en_i && (code_i == CODE_W'(1)) && op_en_i[0]) begin
      fixed_wsta_chk: assert (op_o == OP_WSTA);
    end
  end

endmodule

// File: rtl/spi_slave_fsm.sv
`timescale 1ns/1ps
module spi_slave_fsm
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BUF_AW   = 4,
  parameter int unsigned DLEN_W   = 8,
  parameter int unsigned ALEN_W   = 6,
  parameter int unsigned OPC_W    = 4,
  localparam int unsigned SLEN_W  = $clog2(DATA_W),
  localparam int unsigned CNT_W   = (DLEN_W > ALEN_W) ? DLEN_W : ALEN_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      rise_i,
  input  logic                      cs_i,
  input  logic                      mosi_i,
  output logic                      miso_o,
  output logic [CODE_W-1:0]         code_o,
  input  op_e                       dec_op_i,
  input  logic                      dec_hit_i,
  input  logic [NUM_OPS-1:0]        dummy_en_i,
  input  logic [NUM_OPS*DLEN_W-1:0] dummy_len_i,
  input  logic [ALEN_W-1:0]         wbuf_alen_i,
  input  logic [ALEN_W-1:0]         rbuf_alen_i,
  input  logic                      rb_sel_i,
  input  logic [SLEN_W-1:0]         stat_len_i,
  input  logic [DATA_W-1:0]         host_status_i,
  output logic [DATA_W-1:0]         master_status_o,
  output logic                      we_o,
  output logic [BUF_AW-1:0]         idx_o,
  output logic [DATA_W-1:0]         wdata_o,
  input  logic [DATA_W-1:0]         rdata_i,
  output logic [2:0]                last_cmd_o,
  output logic [OPC_W-1:0]          op_count_o
);

  st_e                st_q,   st_n;
  logic [CNT_W-1:0]   cnt_q,  cnt_n;
  logic [CODE_W-2:0]  cmd_q,  cmd_n;
  op_e                op_q,   op_n;
  logic [BUF_AW-1:0]  adr_q,  adr_n;
  logic [BUF_AW-1:0]  idx_q,  idx_n;
  logic [DATA_W-1:0]  rx_q,   rx_n;
  logic [DATA_W-1:0]  tx_q,   tx_n;
  logic [DATA_W-1:0]  mst_q,  mst_n;
  op_e                last_q, last_n;
  logic [OPC_W-1:0]   opc_q,  opc_n;
  logic               we_q,   we_n;
  logic [DATA_W-1:0]  wd_q,   wd_n;

  logic [1:0]         dec_idx, cur_idx;
  logic [ALEN_W-1:0]  alen_cur;
  logic [DLEN_W-1:0]  dlen_cur;
  logic [CNT_W-1:0]   dlim;
  logic [BUF_AW:0]    adr_wide;
  logic [BUF_AW-1:0]  adr_shift;
  logic [DATA_W-1:0]  rx_shift;
  logic [DATA_W-1:0]  stat_src;
  logic [DATA_W-1:0]  stat_aligned;
  logic               stat_op;

  assign code_o       = {cmd_q, mosi_i};
  assign dec_idx      = 2'(3'(dec_op_i) - 3'd1);
  assign cur_idx      = 2'(3'(op_q) - 3'd1);
  assign alen_cur     = (op_q == OP_RBUF) ? rbuf_alen_i : wbuf_alen_i;
  assign dlen_cur     = dummy_len_i[cur_idx*DLEN_W +: DLEN_W];
  assign stat_op      = (op_q == OP_WSTA) || (op_q == OP_RSTA);
  assign dlim         = stat_op ? CNT_W'(stat_len_i) : CNT_W'(DATA_W - 1);
  assign adr_wide     = {adr_q, mosi_i};
  assign adr_shift    = adr_wide[BUF_AW-1:0];
  assign rx_shift     = {rx_q[DATA_W-2:0], mosi_i};
  assign stat_src     = rb_sel_i ? mst_q : host_status_i;
  assign stat_aligned = stat_src << (SLEN_W'(DATA_W - 1) - stat_len_i);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    cmd_n  = cmd_q;
    op_n   = op_q;
    adr_n  = adr_q;
    idx_n  = idx_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    mst_n  = mst_q;
    last_n = last_q;
    opc_n  = opc_q;
    we_n   = 1'b0;
    wd_n   = wd_q;
    if (clr_i) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      cmd_n  = '0;
      op_n   = OP_NONE;
      adr_n  = '0;
      idx_n  = '0;
      rx_n   = '0;
      tx_n   = '0;
      mst_n  = '0;
      last_n = OP_NONE;
      opc_n  = '0;
      wd_n   = '0;
    end else if (cs_i) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      op_n  = OP_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_n  = ST_CMD;
          cnt_n = '0;
          cmd_n = '0;
        end
        ST_CMD: begin
          if (rise_i) begin
            cmd_n = code_o[CODE_W-2:0];
            if (cnt_q == CNT_W'(CODE_W - 1)) begin
              cnt_n = '0;
              rx_n  = '0;
              if (dec_hit_i) begin
                op_n   = dec_op_i;
                last_n = dec_op_i;
                if ((dec_op_i == OP_WBUF) || (dec_op_i == OP_RBUF)) st_n = ST_ADDR;
                else if (dummy_en_i[dec_idx])                       st_n = ST_DUMMY;
                else                                                st_n = data_entry(dec_op_i);
              end else begin
                st_n = ST_HALT;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_ADDR: begin
          if (rise_i) begin
            adr_n = adr_shift;
            if (cnt_q == CNT_W'(alen_cur)) begin
              cnt_n = '0;
              idx_n = adr_shift;
              st_n  = dummy_en_i[cur_idx] ? ST_DUMMY : data_entry(op_q);
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_DUMMY: begin
          if (rise_i) begin
            if (cnt_q == CNT_W'(dlen_cur)) begin
              cnt_n = '0;
              st_n  = data_entry(op_q);
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          tx_n  = (op_q == OP_RSTA) ? stat_aligned : rdata_i;
          cnt_n = '0;
          st_n  = ST_DATA;
        end
        ST_DATA: begin
          if (rise_i) begin
            rx_n = rx_shift;
            tx_n = tx_q << 1;
            if (cnt_q == dlim) begin
              cnt_n = '0;
              st_n  = ST_HALT;
              opc_n = opc_q + 1'b1;
              if (op_q == OP_WSTA) mst_n = rx_shift;
              if (op_q == OP_WBUF) begin
                we_n = 1'b1;
                wd_n = rx_shift;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ST_HALT: begin
          st_n = ST_HALT;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cmd_q  <= '0;
      op_q   <= OP_NONE;
      adr_q  <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      mst_q  <= '0;
      last_q <= OP_NONE;
      opc_q  <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      cmd_q  <= cmd_n;
      op_q   <= op_n;
      adr_q  <= adr_n;
      idx_q  <= idx_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      mst_q  <= mst_n;
      last_q <= last_n;
      opc_q  <= opc_n;
      we_q   <= we_n;
      wd_q   <= wd_n;
    end
  end

  assign miso_o          = (st_q == ST_DATA) && op_is_read(op_q) && tx_q[DATA_W-1];
  assign master_status_o = mst_q;
  assign we_o            = we_q;
  assign idx_o           = idx_q;
  assign wdata_o         = wd_q;
  assign last_cmd_o      = last_q;
  assign op_count_o      = opc_q;

  // R8
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_i |=> ((st_q == ST_IDLE) && !miso_o));

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((opc_q != $past(opc_q)) && !$past(clr_i)) |-> (opc_q == OPC_W'($past(opc_q) + 1'b1)));

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |=> ((st_q == ST_HALT) || (st_q == ST_IDLE)));

  // R1
  last_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((last_q != $past(last_q)) && !$past(clr_i)) |->
      (last_q inside {OP_WSTA, OP_WBUF, OP_RBUF, OP_RSTA}));

endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BUF_AW  = 4,
  parameter int unsigned DLEN_W  = 8,
  parameter int unsigned ALEN_W  = 6,
  parameter int unsigned OPC_W   = 4,
  parameter int unsigned SYNC_ST = 2,
  localparam int unsigned SLEN_W = $clog2(DATA_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_clr,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  input  logic                      cmd_prog_en,
  input  logic [NUM_OPS*CODE_W-1:0] cmd_codes,
  input  logic                      sta_en,
  input  logic                      wbuf_en,
  input  logic                      rbuf_en,
  input  logic [NUM_OPS-1:0]        dummy_en,
  input  logic [NUM_OPS*DLEN_W-1:0] dummy_len,
  input  logic [ALEN_W-1:0]         wbuf_alen,
  input  logic [ALEN_W-1:0]         rbuf_alen,
  input  logic                      stat_rb_sel,
  input  logic [SLEN_W-1:0]         stat_len,
  input  logic [DATA_W-1:0]         host_status,
  output logic [DATA_W-1:0]         master_status,
  output logic                      buf_we,
  output logic [BUF_AW-1:0]         buf_waddr,
  output logic [DATA_W-1:0]         buf_wdata,
  output logic [BUF_AW-1:0]         buf_raddr,
  input  logic [DATA_W-1:0]         buf_rdata,
  output logic [2:0]                last_cmd,
  output logic [OPC_W-1:0]          op_count
);

  logic [2:0]         pins_sync;
  logic               sclk_rise;
  logic [CODE_W-1:0]  cmd_code;
  op_e                dec_op;
  logic               dec_hit;
  logic [NUM_OPS-1:0] op_en;
  logic [BUF_AW-1:0]  word_idx;

  assign op_en = {sta_en, rbuf_en, wbuf_en, sta_en};

  spi_pin_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_ST),
    .RST_VAL (3'b010),
    .EDGE_BIT(0)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({spi_mosi, spi_cs_n, spi_sclk}),
    .sync_o (pins_sync),
    .rise_o (sclk_rise)
  );

  spi_cmd_match #(
    .CODE_W(CODE_W),
    .N_OPS (NUM_OPS)
  ) u_match (
    .code_i       (cmd_code),
    .prog_en_i    (cmd_prog_en),
    .prog_codes_i (cmd_codes),
    .op_en_i      (op_en),
    .op_o         (dec_op),
    .hit_o        (dec_hit)
  );

  spi_slave_fsm #(
    .CODE_W(CODE_W),
    .DATA_W(DATA_W),
    .BUF_AW(BUF_AW),
    .DLEN_W(DLEN_W),
    .ALEN_W(ALEN_W),
    .OPC_W (OPC_W)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .clr_i           (soft_clr),
    .rise_i          (sclk_rise),
    .cs_i            (pins_sync[1]),
    .mosi_i          (pins_sync[2]),
    .miso_o          (spi_miso),
    .code_o          (cmd_code),
    .dec_op_i        (dec_op),
    .dec_hit_i       (dec_hit),
    .dummy_en_i      (dummy_en),
    .dummy_len_i     (dummy_len),
    .wbuf_alen_i     (wbuf_alen),
    .rbuf_alen_i     (rbuf_alen),
    .rb_sel_i        (stat_rb_sel),
    .stat_len_i      (stat_len),
    .host_status_i   (host_status),
    .master_status_o (master_status),
    .we_o            (buf_we),
    .idx_o           (word_idx),
    .wdata_o         (buf_wdata),
    .rdata_i         (buf_rdata),
    .last_cmd_o      (last_cmd),
    .op_count_o      (op_count)
  );

  assign buf_waddr = word_idx;
  assign buf_raddr = word_idx;

endmodule

// File: tb/spi_cmd_slave_bench.sv
`timescale 1ns/1ps
module spi_cmd_slave_bench;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n, soft_clr, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic        cmd_prog_en, sta_en, wbuf_en, rbuf_en, stat_rb_sel;
  logic [31:0] cmd_codes, dummy_len, host_status, master_status;
  logic [3:0]  dummy_en, buf_waddr, buf_raddr, op_count;
  logic [5:0]  wbuf_alen, rbuf_alen;
  logic [4:0]  stat_len;
  logic        buf_we;
  logic [31:0] buf_wdata, buf_rdata;
  logic [2:0]  last_cmd;

  logic [31:0] mem [16];
  int          we_cnt = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  spi_cmd_slave u_spi_cmd_slave (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .cmd_prog_en(cmd_prog_en), .cmd_codes(cmd_codes),
    .sta_en(sta_en), .wbuf_en(wbuf_en), .rbuf_en(rbuf_en),
    .dummy_en(dummy_en), .dummy_len(dummy_len),
    .wbuf_alen(wbuf_alen), .rbuf_alen(rbuf_alen),
    .stat_rb_sel(stat_rb_sel), .stat_len(stat_len),
    .host_status(host_status), .master_status(master_status),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .last_cmd(last_cmd), .op_count(op_count)
  );

  assign buf_rdata = mem[buf_raddr];

  always @(posedge clk) begin
    if (buf_we) begin
      mem[buf_waddr] <= buf_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  // {prog, code, expected op (0 = unchanged)}
  localparam logic [11:0] VEC [11] = '{
    {1'b0, 8'h01, 3'd1}, {1'b0, 8'h02, 3'd2}, {1'b0, 8'h03, 3'd3},
    {1'b0, 8'h04, 3'd4}, {1'b0, 8'h05, 3'd0}, {1'b0, 8'hA1, 3'd0},
    {1'b1, 8'hA1, 3'd1}, {1'b1, 8'h01, 3'd0}, {1'b1, 8'hD4, 3'd4},
    {1'b1, 8'hC3, 3'd3}, {1'b1, 8'hB2, 3'd2}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [63:0] dout,
                      output logic [63:0] din, output logic quiet);
    din = '0;
    quiet = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = dout[i];
      repeat (H) @(negedge clk);
      spi_sclk = 1'b1;
      din = {din[62:0], spi_miso};
      if (spi_miso !== 1'b0) quiet = 1'b0;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic        q;
    logic [2:0]  prev;
    for (int i = 0; i < 16; i++) mem[i] = 32'h5A00_0000 + 32'(i);
    rst_n = 1'b0; soft_clr = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    cmd_prog_en = 1'b0; cmd_codes = 32'hD4C3_B2A1;
    sta_en = 1'b1; wbuf_en = 1'b1; rbuf_en = 1'b1;
    dummy_en = 4'b0000; dummy_len = '0; wbuf_alen = 6'd7; rbuf_alen = 6'd3;
    stat_rb_sel = 1'b1; stat_len = 5'd15; host_status = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 reset last_cmd", 64'(last_cmd), 64'd0);
    chk("R12 reset op_count", 64'(op_count), 64'd0);
    chk("R12 reset master_status", 64'(master_status), 64'd0);
    chk("R12 reset miso/we", 64'({spi_miso, buf_we}), 64'd0);

    // R1 / R2 decode table, each frame aborted after the command (R8)
    prev = 3'd0;
    for (int v = 0; v < 11; v++) begin
      cmd_prog_en = VEC[v][11];
      cs_lo();
      xfer(8, 64'(VEC[v][10:3]), d, q);
      cs_hi();
      if (VEC[v][2:0] != 3'd0) prev = VEC[v][2:0];
      chk(VEC[v][11] ? "R2 programmable decode" : "R1 fixed decode", 64'(last_cmd), 64'(prev));
      chk("R8 aborted frame not counted", 64'(op_count), 64'd0);
    end
    cmd_prog_en = 1'b0;

    // R3 write status, 16 bits
    cs_lo(); xfer(8, 64'h01, d, q); xfer(16, 64'hBEEF, d, q); cs_hi();
    chk("R3 master_status", 64'(master_status), 64'h0000_BEEF);
    chk("R11 count after write status", 64'(op_count), 64'd1);

    // R4 / R7 read status of master status with a 2-cycle dummy phase
    dummy_en = 4'b1000; dummy_len = 32'h0100_0000;
    cs_lo(); xfer(8, 64'h04, d, q); xfer(2, 64'h3, d, q);
    chk("R7 miso quiet during dummy", 64'(q), 64'd1);
    xfer(16, 64'h0, d, q); cs_hi();
    chk("R4 read master status", d, 64'h0000_BEEF);
    chk("R11 count after read status", 64'(op_count), 64'd2);

    // R4 read host status, 32 bits, no dummy
    dummy_en = 4'b0000; stat_rb_sel = 1'b0; stat_len = 5'd31; host_status = 32'h1234_5678;
    cs_lo(); xfer(8, 64'h04, d, q); xfer(32, 64'h0, d, q); cs_hi();
    chk("R4 read host status", d, 64'h1234_5678);

    // R5 / R7 write buffer, 8 address bits, 3 dummy cycles
    dummy_en = 4'b0010; dummy_len = 32'h0000_0200; wbuf_alen = 6'd7;
    cs_lo(); xfer(8, 64'h02, d, q); xfer(8, 64'h25, d, q); xfer(3, 64'h0, d, q);
    xfer(32, 64'hCAFE_F00D, d, q); cs_hi();
    chk("R5 word written", 64'(mem[5]), 64'hCAFE_F00D);
    chk("R5 neighbour untouched", 64'(mem[4]), 64'h5A00_0004);
    chk("R5 single strobe", 64'(we_cnt), 64'd1);
    chk("R11 count after write buffer", 64'(op_count), 64'd4);

    // R6 read buffer, 4 address bits
    dummy_en = 4'b0000; rbuf_alen = 6'd3;
    cs_lo(); xfer(8, 64'h03, d, q); xfer(4, 64'h9, d, q); xfer(32, 64'h0, d, q); cs_hi();
    chk("R6 read word 9", d, 64'h5A00_0009);
    cs_lo(); xfer(8, 64'h03, d, q); xfer(4, 64'h5, d, q); xfer(32, 64'h0, d, q); cs_hi();
    chk("R6 read word 5", d, 64'hCAFE_F00D);
    chk("R11 count after read buffer", 64'(op_count), 64'd6);

    // R9 unknown command
    cs_lo(); xfer(8, 64'h77, d, q); xfer(16, 64'hFFFF, d, q); cs_hi();
    chk("R9 miso quiet", 64'(q), 64'd1);
    chk("R9 last_cmd kept", 64'(last_cmd), 64'd3);
    chk("R9 count kept", 64'(op_count), 64'd6);

    // R10 disabled commands
    sta_en = 1'b0; stat_len = 5'd15;
    cs_lo(); xfer(8, 64'h01, d, q); xfer(16, 64'h1234, d, q); cs_hi();
    chk("R10 status disabled", 64'(master_status), 64'h0000_BEEF);
    chk("R10 last_cmd kept", 64'(last_cmd), 64'd3);
    sta_en = 1'b1; wbuf_en = 1'b0;
    cs_lo(); xfer(8, 64'h02, d, q); xfer(8, 64'h25, d, q); xfer(32, 64'h1111_2222, d, q); cs_hi();
    chk("R10 write buffer disabled", 64'(mem[5]), 64'hCAFE_F00D);
    chk("R10 count kept", 64'(op_count), 64'd6);
    wbuf_en = 1'b1;

    // R8 abort in the middle of the data phase
    cs_lo(); xfer(8, 64'h01, d, q); xfer(8, 64'hAA, d, q); cs_hi();
    chk("R8 status untouched", 64'(master_status), 64'h0000_BEEF);
    chk("R8 count untouched", 64'(op_count), 64'd6);

    // R11 wrap with 1-bit status writes: 6 + 10 = 16 -> 0
    stat_len = 5'd0;
    for (int k = 0; k < 10; k++) begin
      cs_lo(); xfer(8, 64'h01, d, q); xfer(1, 64'h1, d, q); cs_hi();
    end
    chk("R11 counter wrap", 64'(op_count), 64'd0);
    chk("R3 one-bit status", 64'(master_status), 64'd1);

    // R12 soft clear
    cs_lo(); xfer(8, 64'h01, d, q); xfer(1, 64'h1, d, q); cs_hi();
    chk("R11 count after wrap", 64'(op_count), 64'd1);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    @(negedge clk);
    chk("R12 clear count", 64'(op_count), 64'd0);
    chk("R12 clear last_cmd", 64'(last_cmd), 64'd0);
    chk("R12 clear master_status", 64'(master_status), 64'd0);

    finish_run();
  end

endmodule